// File: doc/BRIEF.md
# Dual-Channel DDR I/Q Receive Bridge

This block sits between a dual-channel data converter and the user's baseband logic. Each of the two channels (A and B) delivers its samples on a 12-bit bus at double data rate, with I and Q interleaved. The converter also sends a clock for that bus. The bridge captures each bus with that clock: the rising edge carries I and the falling edge carries Q. It pairs the two words in the converter's clock domain, so the pair changes on a single edge.

The paired words then pass through one flip-flop stage clocked by the user's receive sample clock, which appears as separate parallel I and Q outputs for each channel. The integrator must make sure the converter clocks run at the same frequency as the user sample clock. Each channel also has an I/Q select pin. The bridge leaves it unused, because the double-data-rate framing already identifies the I and Q words.

Top module: `ddr_iq_rx_bridge`

## Requirements
- R1: The word on a channel's data bus at a rising edge of that channel's receive clock appears on that channel's I output.
- R2: The word on a channel's data bus at the next falling edge of the same receive clock appears on that channel's Q output.
- R3: The I and Q words of one receive clock cycle reach the outputs together, on the first rising edge of the user clock after that cycle's falling edge, and they stay there until the next such edge.
- R4: Channels A and B work independently. Each has its own receive clock, and the receive clocks may differ in phase from each other and from the user clock.
- R5: The per-channel I/Q select inputs have no effect on any output.
- R6: The reset input is active low and is sampled on the rising edge of the user clock. At any user clock edge where it is sampled low, all four outputs become zero, and they stay zero while it remains low.
- R7: All 12 bits pass through unchanged, including all-zero, all-one and alternating bit patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_user | input | 1 | User receive sample clock; drives the output registers |
| rst_n | input | 1 | Synchronous active-low reset for the output registers |
| rx_clk_a | input | 1 | Channel A receive clock from the converter |
| rx_data_a | input | 12 | Channel A DDR data: I on rising edge, Q on falling edge |
| rx_sel_a | input | 1 | Channel A I/Q select, unused |
| rx_clk_b | input | 1 | Channel B receive clock from the converter |
| rx_data_b | input | 12 | Channel B DDR data: I on rising edge, Q on falling edge |
| rx_sel_b | input | 1 | Channel B I/Q select, unused |
| i_a | output | 12 | Channel A I sample |
| q_a | output | 12 | Channel A Q sample |
| i_b | output | 12 | Channel B I sample |
| q_b | output | 12 | Channel B Q sample |

## Verification
Two faults are hard to see from the ports: an I/Q swap and an edge that pairs a Q with the wrong I. Both stay hidden whenever I equals Q or consecutive samples are alike. The stimulus therefore gives every I word a different value from its Q word and from its neighbours. It runs channel B's receive clock 1 ns behind channel A's, so the two capture paths see different edge timing relative to the user clock. A reset pulse in the middle of a live stream shows that clearing happens only in the user domain and that the very next pair passes straight through afterwards.

// File: rtl/ddr_iq_pkg.sv
// Package: shared constants for the DDR I/Q receive bridge.
// Assumes: every channel uses the same sample width.
package ddr_iq_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Default width of one converter sample word.
    localparam int IQ_SAMPLE_W = 12;
    // Number of receive channels the bridge serves.
    localparam int IQ_NUM_CH   = 2;
endpackage

// File: rtl/ddr_iq_capture.sv
// Module: ddr_iq_capture
// Does: captures one DDR bus in the converter clock domain. The rising-edge
//       word is I and the falling-edge word is Q. Both are loaded into an
//       output pair on the falling edge, so the pair changes on one edge only.
// Assumes: the data meets setup and hold time around both edges of rx_clk.
//          There is no reset here, because this domain has no reset of its own.
module ddr_iq_capture #(
    parameter int SAMPLE_W = ddr_iq_pkg::IQ_SAMPLE_W
) (
    input  logic                rx_clk,
    input  logic [SAMPLE_W-1:0] rx_din,
    output logic [SAMPLE_W-1:0] pair_i,
    output logic [SAMPLE_W-1:0] pair_q
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [SAMPLE_W-1:0] rise_word;

    // Hold the rising-edge (I) word until its Q partner arrives.
    always_ff @(posedge rx_clk) begin
        rise_word <= rx_din;
    end

    // Load the I/Q pair together on the falling edge.
    always_ff @(negedge rx_clk) begin
        pair_i <= rise_word;
        pair_q <= rx_din;
    end
endmodule

// File: rtl/ddr_iq_retime.sv
// Module: ddr_iq_retime
// Does: re-registers one I/Q pair in the user sample clock domain, with a
//       synchronous active-low clear.
// Assumes: the source pair changes once per user clock period, at the same
//          frequency as the user clock, and never near a user rising edge.
module ddr_iq_retime #(
    parameter int SAMPLE_W = ddr_iq_pkg::IQ_SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] src_i,
    input  logic [SAMPLE_W-1:0] src_q,
    output logic [SAMPLE_W-1:0] out_i,
    output logic [SAMPLE_W-1:0] out_q
);
    timeunit 1ns;
    timeprecision 1ps;

    // Single retiming stage; cleared while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_i <= '0;
            out_q <= '0;
        end else begin
            out_i <= src_i;
            out_q <= src_q;
        end
    end

    // R6
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_i == '0 && out_q == '0))
        else $error("outputs not cleared by reset");
endmodule

// File: rtl/ddr_iq_channel.sv
// Module: ddr_iq_channel
// Does: one receive channel, made of the converter-domain DDR capture followed
//       by the user-domain retiming stage. The captured pair is also exported
//       so the top level can observe it.
// Assumes: rx_clk runs at the same frequency as clk.
module ddr_iq_channel #(
    parameter int SAMPLE_W = ddr_iq_pkg::IQ_SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_clk,
    input  logic [SAMPLE_W-1:0] rx_din,
    output logic [SAMPLE_W-1:0] cap_i,
    output logic [SAMPLE_W-1:0] cap_q,
    output logic [SAMPLE_W-1:0] out_i,
    output logic [SAMPLE_W-1:0] out_q
);
    timeunit 1ns;
    timeprecision 1ps;

    ddr_iq_capture #(.SAMPLE_W(SAMPLE_W)) u_capture (
        .rx_clk (rx_clk),
        .rx_din (rx_din),
        .pair_i (cap_i),
        .pair_q (cap_q)
    );

    ddr_iq_retime #(.SAMPLE_W(SAMPLE_W)) u_retime (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (cap_i),
        .src_q (cap_q),
        .out_i (out_i),
        .out_q (out_q)
    );

    // R1 R3
    i_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_i == $past(cap_i)))
        else $error("I output does not follow captured pair");

    // R2 R3
    q_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_q == $past(cap_q)))
        else $error("Q output does not follow captured pair");
endmodule

// File: rtl/ddr_iq_rx_bridge.sv
// Module: ddr_iq_rx_bridge
// Does: top level of the two-channel DDR I/Q receive bridge. It gathers the
//       per-channel pins into arrays and generates one channel per entry.
// Assumes: both receive clocks match clk_user in frequency. The select pins
//          are unused, because the DDR framing already identifies I and Q.
module ddr_iq_rx_bridge #(
    parameter int SAMPLE_W = ddr_iq_pkg::IQ_SAMPLE_W
) (
    input  logic                clk_user,
    input  logic                rst_n,
    input  logic                rx_clk_a,
    input  logic [SAMPLE_W-1:0] rx_data_a,
    input  logic                rx_sel_a,
    input  logic                rx_clk_b,
    input  logic [SAMPLE_W-1:0] rx_data_b,
    input  logic                rx_sel_b,
    output logic [SAMPLE_W-1:0] i_a,
    output logic [SAMPLE_W-1:0] q_a,
    output logic [SAMPLE_W-1:0] i_b,
    output logic [SAMPLE_W-1:0] q_b
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NCH = ddr_iq_pkg::IQ_NUM_CH;

    logic [NCH-1:0]      ch_clk;
    logic [SAMPLE_W-1:0] ch_din [NCH];
    logic [SAMPLE_W-1:0] ch_cap_i [NCH];
    logic [SAMPLE_W-1:0] ch_cap_q [NCH];
    logic [SAMPLE_W-1:0] ch_out_i [NCH];
    logic [SAMPLE_W-1:0] ch_out_q [NCH];

    // Gather the per-channel pins into indexed form.
    assign ch_clk    = {rx_clk_b, rx_clk_a};
    assign ch_din[0] = rx_data_a;
    assign ch_din[1] = rx_data_b;

    // One channel instance per receive path.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ddr_iq_channel #(.SAMPLE_W(SAMPLE_W)) u_ch (
            .clk    (clk_user),
            .rst_n  (rst_n),
            .rx_clk (ch_clk[c]),
            .rx_din (ch_din[c]),
            .cap_i  (ch_cap_i[c]),
            .cap_q  (ch_cap_q[c]),
            .out_i  (ch_out_i[c]),
            .out_q  (ch_out_q[c])
        );
    end

    // Drive the named output pins from the channel array.
    assign i_a = ch_out_i[0];
    assign q_a = ch_out_q[0];
    assign i_b = ch_out_i[1];
    assign q_b = ch_out_q[1];

    // R5
    sel_a_ignored_chk: assert property (@(posedge clk_user) disable iff (!rst_n)
        ($past(rst_n) && $changed(rx_sel_a)) |->
        (i_a == $past(ch_cap_i[0]) && q_a == $past(ch_cap_q[0])))
        else $error("channel A output disturbed by select");

    // R5 R4
    sel_b_ignored_chk: assert property (@(posedge clk_user) disable iff (!rst_n)
        ($past(rst_n) && $changed(rx_sel_b)) |->
        (i_b == $past(ch_cap_i[1]) && q_b == $past(ch_cap_q[1])))
        else $error("channel B output disturbed by select");
endmodule

// File: tb/ddr_iq_rx_bridge_tb.sv
// Bench for ddr_iq_rx_bridge. A behavioural queue model predicts every output
// on every user clock edge. Channel A's receive clock is in phase with the
// 200 MHz user clock, and channel B's trails it by 1 ns.
module ddr_iq_rx_bridge_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W      = 12;
    localparam int CYCLES = 170;

    logic          clk_user = 1'b0;
    logic          rx_clk_a = 1'b0;
    logic          rx_clk_b = 1'b0;
    logic          rst_n    = 1'b0;
    logic [W-1:0]  rx_data_a = '0;
    logic [W-1:0]  rx_data_b = '0;
    logic          rx_sel_a = 1'b0;
    logic          rx_sel_b = 1'b0;
    logic [W-1:0]  i_a, q_a, i_b, q_b;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [2*W-1:0] exp_a[$];
    logic [2*W-1:0] exp_b[$];

    ddr_iq_rx_bridge u_dut (
        .clk_user (clk_user), .rst_n (rst_n),
        .rx_clk_a (rx_clk_a), .rx_data_a (rx_data_a), .rx_sel_a (rx_sel_a),
        .rx_clk_b (rx_clk_b), .rx_data_b (rx_data_b), .rx_sel_b (rx_sel_b),
        .i_a (i_a), .q_a (q_a), .i_b (i_b), .q_b (q_b)
    );

    // 200 MHz user clock, with channel A's receive clock in phase.
    always #2.5 clk_user = ~clk_user;
    always #2.5 rx_clk_a = ~rx_clk_a;
    // Channel B's receive clock: same rate, 1 ns later.
    initial begin
        #1;
        forever #2.5 rx_clk_b = ~rx_clk_b;
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%03h expected=%03h at %0t", tag, act, exp, $time);
        end
    endtask

    // Sample word for cycle k, channel ch, q=1 selects the Q word.
    function automatic logic [W-1:0] gen(input int k, input int ch, input bit q);
        logic [W-1:0] v;
        if (k < 41) begin
            v = W'(k * 6 + (q ? 3 : 0) + ch * 700 + 1);
        end else if (k < 81) begin
            case (k % 4)
                0: v = q ? 12'hFFF : 12'h000;
                1: v = q ? 12'h000 : 12'hFFF;
                2: v = q ? 12'h555 : 12'hAAA;
                default: v = q ? 12'hAAA : 12'h555;
            endcase
            if (ch == 1) v = ~v;
        end else begin
            v = W'($urandom);
        end
        return v;
    endfunction

    function automatic string phase_tag(input int k);
        if (k < 41) return " R3";
        if (k < 81) return " R7";
        return " R5";
    endfunction

    // Stimulus and per-clock comparison against the queue model.
    initial begin
        logic [W-1:0] cur_ai, cur_bi, qv;
        logic [2*W-1:0] pa, pb;
        bit rs;
        cur_ai = gen(0, 0, 1'b0);
        cur_bi = gen(0, 1, 1'b0);
        rx_data_a = cur_ai;
        rx_data_b = cur_bi;
        for (int k = 0; k < CYCLES; k++) begin
            @(posedge clk_user);
            #0.5;
            rs = rst_n;
            pa = (exp_a.size() > 0) ? exp_a.pop_front() : '0;
            pb = (exp_b.size() > 0) ? exp_b.pop_front() : '0;
            if (!rs) begin
                chk("R6 i_a", i_a, '0);
                chk("R6 q_a", q_a, '0);
                chk("R6 R4 i_b", i_b, '0);
                chk("R6 R4 q_b", q_b, '0);
            end else begin
                chk({"R1 i_a", phase_tag(k - 1)}, i_a, pa[2*W-1:W]);
                chk({"R2 q_a", phase_tag(k - 1)}, q_a, pa[W-1:0]);
                chk({"R1 R4 i_b", phase_tag(k - 1)}, i_b, pb[2*W-1:W]);
                chk({"R2 R4 q_b", phase_tag(k - 1)}, q_b, pb[W-1:0]);
            end
            // T+1.25: channel A Q word, ahead of A's falling edge at T+2.5.
            #0.75;
            qv = gen(k, 0, 1'b1);
            rx_data_a = qv;
            exp_a.push_back({cur_ai, qv});
            // T+2: reset schedule and select toggling.
            #0.75;
            if (k == 4 || k == 124) rst_n = 1'b1;
            if (k == 121) rst_n = 1'b0;
            if (k >= 81) begin
                rx_sel_a = 1'($urandom);
                rx_sel_b = 1'($urandom);
            end
            // T+2.25: channel B Q word, ahead of B's falling edge at T+3.5.
            #0.25;
            qv = gen(k, 1, 1'b1);
            rx_data_b = qv;
            exp_b.push_back({cur_bi, qv});
            // T+3.75: next channel A I word.
            #1.5;
            cur_ai = gen(k + 1, 0, 1'b0);
            rx_data_a = cur_ai;
            // T+4.5: next channel B I word.
            #0.75;
            cur_bi = gen(k + 1, 1, 1'b0);
            rx_data_b = cur_bi;
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #20000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule